// File: doc/BRIEF.md
# Hardware Breakpoint Trigger Bank

This block holds a small set of address-comparison triggers that a processor core uses to stop on a chosen instruction, load or store. Software never addresses a trigger directly. It first writes a trigger number into an index register. The control and address registers that follow then act on that trigger. Each cycle the bank watches the fetch stream, the load address, the store address and the current privilege level. It raises a one-cycle debug-entry request when any enabled trigger sees an exact address match.

The control word describes its own trigger. The top nibble reports the trigger kind and cannot be written. The low seven bits enable matching per access kind and per privilege level. Bits that a trigger does not implement read back as zero, so a debugger can look for a free trigger and confirm its capabilities by reading after it writes. The match-mode and action fields only keep exact comparison and debug entry, so they always read as zero. An index at or above the number of built triggers selects nothing.

Top module: `bp_trigger_bank`

## Requirements
- R1: After reset every trigger is disabled, the index register reads 0 and `dbg_req` is low.
- R2: CSR 0x7a0 holds a 5-bit trigger index that reads back as written. CSRs 0x7a1 and 0x7a2 act on the trigger that this index names.
- R3: Control bits 6:0 are writable and read back: bit0 execute, bit1 store, bit2 load, bit3 user, bit4 supervisor, bit5 hypervisor, bit6 machine.
- R4: Control bits XLEN-1:XLEN-4 always read 1 for a built trigger and ignore writes.
- R5: Control bits 10:7 (match mode, exact = 0) and 18:11 (action, debug entry = 0), and every other bit between 7 and XLEN-5, always read 0 after any write.
- R6: A trigger built without execute support (by default trigger 3) reads bit0 as 0 after a write of 1 and never fires on a fetch.
- R7: CSR 0x7a2 holds a full XLEN-bit match address for the selected trigger.
- R8: A valid fetch whose PC equals the address of a trigger raises `dbg_req` for exactly one cycle, on the clock edge after the fetch. The trigger must have execute and the current privilege bit set.
- R9: A valid load (store) whose address equals a trigger's address raises `dbg_req` on the next edge. The trigger must have the load (store) bit and the current privilege bit set.
- R10: `cur_priv` encodes 0 user, 1 supervisor, 2 hypervisor, 3 machine. A trigger does not fire while the bit for the current level is clear.
- R11: Writing 0 to a control word stops that trigger from firing.
- R12: With an index of NUM_TRIG or more, the control and address CSRs read 0 (type 0), and writes to them change no trigger.
- R13: CSR 0x7a3 reads 0 and ignores writes. Any CSR address outside 0x7a0–0x7a3 also reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR address for read and write |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | Combinational read data for `csr_addr` |
| fetch_valid | input | 1 | A fetch is presented this cycle |
| fetch_pc | input | XLEN | PC of the presented fetch |
| ld_valid | input | 1 | A load is presented this cycle |
| ld_addr | input | XLEN | Load address |
| st_valid | input | 1 | A store is presented this cycle |
| st_addr | input | XLEN | Store address |
| cur_priv | input | 2 | Current privilege level |
| dbg_req | output | 1 | Registered debug-entry request |

## Verification
`csr_rdata` is combinational. It is checked in the same cycle the address is applied, and it reflects every write up to the last clock edge. A register write becomes visible from the cycle after its edge. `dbg_req` passes through one register. The bench predicts it from the inputs and the register state of the cycle before, and compares one full clock later. Inputs change on the falling edge and outputs are sampled on a falling edge, so no compare lands near the active edge.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
   localparam logic [11:0] CSR_IDX  = 12'h7a0;
   localparam logic [11:0] CSR_CTRL = 12'h7a1;
   localparam logic [11:0] CSR_ADDR = 12'h7a2;
   localparam logic [11:0] CSR_AUX  = 12'h7a3;

   localparam int MAX_INDEX = 16;
   localparam int IDX_W     = $clog2(MAX_INDEX + 1);

   localparam int EN_W     = 7;
   localparam int B_EXEC   = 0;
   localparam int B_STORE  = 1;
   localparam int B_LOAD   = 2;
   localparam int B_MODE0  = 3;
   localparam int B_HMODE  = 5;

   localparam int         MODE_LSB    = 7;
   localparam int         MODE_W      = 4;
   localparam int         ACT_W       = 8;
   localparam logic [3:0] MODE_EXACT  = 4'd0;
   localparam logic [7:0] ACT_DEBUG   = 8'd0;
   localparam logic [3:0] KIND_ADDR   = 4'd1;
endpackage

// File: rtl/bpt_index.sv
module bpt_index #(
   parameter int NUM_TRIG = 4,
   parameter int IDX_W    = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   output logic [IDX_W-1:0]    idx_q,
   output logic [NUM_TRIG-1:0] idx_onehot
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     idx_q <= '0;
      else if (wr_en) idx_q <= wr_idx;
   end

   for (genvar t = 0; t < NUM_TRIG; t++) begin : g_dec
      assign idx_onehot[t] = (idx_q == IDX_W'(t));
   end

   AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(idx_q)); // R2
endmodule

// File: rtl/bpt_trigger.sv
module bpt_trigger
   import bpt_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter bit EXEC_CAP  = 1'b1,
   parameter bit HMODE_CAP = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ctrl_we,
   input  logic            addr_we,
   input  logic [XLEN-1:0] wdata,
   input  logic            fetch_valid,
   input  logic [XLEN-1:0] fetch_pc,
   input  logic            ld_valid,
   input  logic [XLEN-1:0] ld_addr,
   input  logic            st_valid,
   input  logic [XLEN-1:0] st_addr,
   input  logic [1:0]      cur_priv,
   output logic [XLEN-1:0] ctrl_rd,
   output logic [XLEN-1:0] addr_rd,
   output logic            hit
);
   localparam int PAD_W = XLEN - 4 - ACT_W - MODE_W - EN_W;

   localparam logic [EN_W-1:0] KEEP_MASK =
        (EN_W'(1) << B_STORE) | (EN_W'(1) << B_LOAD)
      | (EN_W'(4'b1011) << B_MODE0)
      | (EXEC_CAP  ? (EN_W'(1) << B_EXEC)  : '0)
      | (HMODE_CAP ? (EN_W'(1) << B_HMODE) : '0);

   logic [EN_W-1:0] en_q;
   logic [XLEN-1:0] addr_q;
   logic [3:0]      mode_en;
   logic            priv_ok, x_hit, l_hit, s_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         addr_q <= '0;
      end else begin
         if (ctrl_we) en_q   <= wdata[EN_W-1:0] & KEEP_MASK;
         if (addr_we) addr_q <= wdata;
      end
   end

   assign ctrl_rd = {KIND_ADDR, {PAD_W{1'b0}}, ACT_DEBUG, MODE_EXACT, en_q};
   assign addr_rd = addr_q;

   assign mode_en = en_q[B_MODE0 +: 4];
   assign priv_ok = mode_en[cur_priv];
   assign x_hit   = en_q[B_EXEC]  & fetch_valid & (fetch_pc == addr_q);
   assign l_hit   = en_q[B_LOAD]  & ld_valid    & (ld_addr  == addr_q);
   assign s_hit   = en_q[B_STORE] & st_valid    & (st_addr  == addr_q);
   assign hit     = priv_ok & (x_hit | l_hit | s_hit);

   AST_PRIV_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> mode_en[cur_priv]); // R10
   AST_EXEC_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we && wdata[B_EXEC]) |=> (ctrl_rd[B_EXEC] == EXEC_CAP)); // R6
   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_rd[EN_W-1:0] == '0) |-> !hit); // R11
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_we |=> $stable(addr_rd)); // R7
endmodule

// File: rtl/bpt_req.sv
module bpt_req #(
   parameter int NUM_TRIG = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_TRIG-1:0] hit_vec,
   output logic                dbg_req
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dbg_req <= 1'b0;
      else        dbg_req <= |hit_vec;
   end

   AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_req |-> $past(|hit_vec)); // R8
   AST_REQ_DUE: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit_vec) |=> dbg_req); // R9
endmodule

// File: rtl/bp_trigger_bank.sv
module bp_trigger_bank
   import bpt_pkg::*;
#(
   parameter int          XLEN          = 32,
   parameter int          NUM_TRIG      = 4,
   parameter logic [15:0] EXEC_CAP_MASK = 16'hFFF7,
   parameter bit          HMODE_CAP     = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            csr_wr,
   input  logic [11:0]     csr_addr,
   input  logic [XLEN-1:0] csr_wdata,
   output logic [XLEN-1:0] csr_rdata,
   input  logic            fetch_valid,
   input  logic [XLEN-1:0] fetch_pc,
   input  logic            ld_valid,
   input  logic [XLEN-1:0] ld_addr,
   input  logic            st_valid,
   input  logic [XLEN-1:0] st_addr,
   input  logic [1:0]      cur_priv,
   output logic            dbg_req
);
   if (NUM_TRIG < 1 || NUM_TRIG > MAX_INDEX) begin : g_bad_count
      $error("bp_trigger_bank: NUM_TRIG must lie in 1..16");
   end
   if (XLEN < 24) begin : g_bad_xlen
      $error("bp_trigger_bank: XLEN too small for the control layout");
   end

   logic [IDX_W-1:0]    idx_q;
   logic [NUM_TRIG-1:0] idx_oh, ctrl_we_vec, addr_we_vec, hit_vec;
   logic [XLEN-1:0]     ctrl_rd [NUM_TRIG];
   logic [XLEN-1:0]     addr_rd [NUM_TRIG];
   logic                wr_idx, wr_ctrl, wr_addr;
   logic [XLEN-1:0]     sel_ctrl, sel_addr;

   assign wr_idx  = csr_wr && (csr_addr == CSR_IDX);
   assign wr_ctrl = csr_wr && (csr_addr == CSR_CTRL);
   assign wr_addr = csr_wr && (csr_addr == CSR_ADDR);

   bpt_index #(.NUM_TRIG(NUM_TRIG), .IDX_W(IDX_W)) u_index (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_idx),
      .wr_idx     (csr_wdata[IDX_W-1:0]),
      .idx_q      (idx_q),
      .idx_onehot (idx_oh)
   );

   for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
      assign ctrl_we_vec[t] = wr_ctrl & idx_oh[t];
      assign addr_we_vec[t] = wr_addr & idx_oh[t];

      bpt_trigger #(
         .XLEN      (XLEN),
         .EXEC_CAP  (EXEC_CAP_MASK[t]),
         .HMODE_CAP (HMODE_CAP)
      ) u_trig (
         .clk         (clk),
         .rst_n       (rst_n),
         .ctrl_we     (ctrl_we_vec[t]),
         .addr_we     (addr_we_vec[t]),
         .wdata       (csr_wdata),
         .fetch_valid (fetch_valid),
         .fetch_pc    (fetch_pc),
         .ld_valid    (ld_valid),
         .ld_addr     (ld_addr),
         .st_valid    (st_valid),
         .st_addr     (st_addr),
         .cur_priv    (cur_priv),
         .ctrl_rd     (ctrl_rd[t]),
         .addr_rd     (addr_rd[t]),
         .hit         (hit_vec[t])
      );
   end

   always_comb begin
      sel_ctrl = '0;
      sel_addr = '0;
      for (int t = 0; t < NUM_TRIG; t++) begin
         if (idx_oh[t]) begin
            sel_ctrl = sel_ctrl | ctrl_rd[t];
            sel_addr = sel_addr | addr_rd[t];
         end
      end
   end

   always_comb begin
      case (csr_addr)
         CSR_IDX:  csr_rdata = XLEN'(idx_q);
         CSR_CTRL: csr_rdata = sel_ctrl;
         CSR_ADDR: csr_rdata = sel_addr;
         default:  csr_rdata = '0;
      endcase
   end

   bpt_req #(.NUM_TRIG(NUM_TRIG)) u_req (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_vec (hit_vec),
      .dbg_req (dbg_req)
   );

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ctrl_we_vec) && $onehot0(addr_we_vec)); // R2
   AST_OOR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr && idx_q >= IDX_W'(NUM_TRIG)) |-> (ctrl_we_vec == '0 && addr_we_vec == '0)); // R12
endmodule

// File: tb/bp_trigger_bank_tb.sv
module bp_trigger_bank_tb;
   localparam int NT = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_wr = 1'b0;
   logic [11:0] csr_addr = '0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        fetch_valid = 1'b0, ld_valid = 1'b0, st_valid = 1'b0;
   logic [31:0] fetch_pc = '0, ld_addr = '0, st_addr = '0;
   logic [1:0]  cur_priv = 2'd3;
   logic        dbg_req;

   int   n_chk = 0, n_bad = 0;
   bit   done = 1'b0;

   logic [4:0]  m_idx;
   logic [6:0]  m_en [NT];
   logic [31:0] m_addr [NT];

   always #5 clk = ~clk;

   bp_trigger_bank u_dut (
      .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
      .ld_valid(ld_valid), .ld_addr(ld_addr),
      .st_valid(st_valid), .st_addr(st_addr),
      .cur_priv(cur_priv), .dbg_req(dbg_req)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   function automatic logic [6:0] keep_of(input int t);
      return (t == 3) ? 7'h7E : 7'h7F;
   endfunction

   function automatic logic [31:0] m_read(input logic [11:0] a);
      if (a == 12'h7a0) return {27'd0, m_idx};
      if (a == 12'h7a1) return (m_idx < NT) ? {4'h1, 21'd0, m_en[m_idx]} : 32'd0;
      if (a == 12'h7a2) return (m_idx < NT) ? m_addr[m_idx] : 32'd0;
      return 32'd0;
   endfunction

   function automatic logic m_hit();
      logic h = 1'b0;
      for (int t = 0; t < NT; t++) begin
         logic [6:0] e = m_en[t];
         if (e[3 + int'(cur_priv)] &&
             ((e[0] && fetch_valid && fetch_pc == m_addr[t]) ||
              (e[2] && ld_valid && ld_addr == m_addr[t]) ||
              (e[1] && st_valid && st_addr == m_addr[t])))
            h = 1'b1;
      end
      return h;
   endfunction

   task automatic m_write();
      if (csr_addr == 12'h7a0) m_idx = csr_wdata[4:0];
      else if (csr_addr == 12'h7a1 && m_idx < NT) m_en[m_idx] = csr_wdata[6:0] & keep_of(int'(m_idx));
      else if (csr_addr == 12'h7a2 && m_idx < NT) m_addr[m_idx] = csr_wdata;
   endtask

   // one clock: predict, let the edge happen, compare dbg_req at the next falling edge
   task automatic step(input string tag);
      logic e = m_hit();
      if (csr_wr) m_write();
      @(posedge clk);
      @(negedge clk);
      chk(dbg_req === e, tag, {31'd0, dbg_req}, {31'd0, e});
   endtask

   task automatic idle();
      csr_wr = 1'b0; fetch_valid = 1'b0; ld_valid = 1'b0; st_valid = 1'b0;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
      step("R8 idle during write");
      csr_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input string tag);
      logic [31:0] e;
      csr_addr = a;
      #1;
      e = m_read(a);
      chk(csr_rdata === e, tag, csr_rdata, e);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0B17));
      m_idx = '0;
      for (int t = 0; t < NT; t++) begin m_en[t] = '0; m_addr[t] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk(dbg_req === 1'b0, "R1 dbg_req", {31'd0, dbg_req}, 32'd0);
      rd(12'h7a0, "R1 index");
      for (int t = 0; t < NT; t++) begin
         wr(12'h7a0, t);
         rd(12'h7a1, "R1 ctrl");
         rd(12'h7a2, "R1 addr");
      end

      // R2 R3 index routing and enable bits
      wr(12'h7a0, 1);
      rd(12'h7a0, "R2 index readback");
      wr(12'h7a1, 32'h0000_007F);
      rd(12'h7a1, "R3 ctrl readback");
      // R4 R5 read-only kind, zero fields
      wr(12'h7a1, 32'hFFFF_FFFF);
      csr_addr = 12'h7a1; #1;
      chk(csr_rdata[31:28] === 4'h1, "R4 kind nibble", {28'd0, csr_rdata[31:28]}, 32'd1);
      chk(csr_rdata[27:7] === '0, "R5 mode/action zero", {11'd0, csr_rdata[27:7]}, 32'd0);
      // R7 address
      wr(12'h7a2, 32'h8000_1234);
      rd(12'h7a2, "R7 addr readback");
      wr(12'h7a0, 0);
      rd(12'h7a2, "R2 other trigger untouched");

      // R8 execute match (trigger 1, machine mode only)
      wr(12'h7a0, 1);
      wr(12'h7a1, 32'h41);
      fetch_valid = 1'b1; fetch_pc = 32'h8000_1234; cur_priv = 2'd3;
      step("R8 exec hit");
      chk(dbg_req === 1'b1, "R8 pulse high", {31'd0, dbg_req}, 32'd1);
      idle();
      step("R8 pulse ends");
      fetch_valid = 1'b1; fetch_pc = 32'h8000_1238;
      step("R8 near miss");
      // R10 privilege gate
      fetch_pc = 32'h8000_1234; cur_priv = 2'd0;
      step("R10 user blocked");
      cur_priv = 2'd2;
      step("R10 hyp blocked");
      idle();

      // R9 load and store
      wr(12'h7a1, 32'h0C);
      cur_priv = 2'd0; ld_valid = 1'b1; ld_addr = 32'h8000_1234;
      step("R9 load hit");
      idle(); st_valid = 1'b1; st_addr = 32'h8000_1234;
      step("R9 store without store bit");
      idle();
      wr(12'h7a1, 32'h0A);
      st_valid = 1'b1; st_addr = 32'h8000_1234; cur_priv = 2'd0;
      step("R9 store hit");
      idle();

      // R11 disable by zero
      wr(12'h7a1, 32'h0);
      st_valid = 1'b1; ld_valid = 1'b1; ld_addr = 32'h8000_1234;
      step("R11 disabled");
      idle();

      // R6 trigger without execute
      wr(12'h7a0, 3);
      wr(12'h7a1, 32'h41);
      rd(12'h7a1, "R6 exec bit drops");
      wr(12'h7a2, 32'h0000_4000);
      fetch_valid = 1'b1; fetch_pc = 32'h0000_4000; cur_priv = 2'd3;
      step("R6 no exec fire");
      idle();

      // R12 out-of-range index
      wr(12'h7a0, 16);
      wr(12'h7a1, 32'h7F);
      wr(12'h7a2, 32'h55);
      rd(12'h7a1, "R12 ctrl reads zero");
      rd(12'h7a2, "R12 addr reads zero");
      for (int t = 0; t < NT; t++) begin
         wr(12'h7a0, t);
         rd(12'h7a1, "R12 triggers unchanged");
         rd(12'h7a2, "R12 addresses unchanged");
      end

      // R13 auxiliary register
      wr(12'h7a3, 32'hDEAD_BEEF);
      rd(12'h7a3, "R13 aux zero");
      rd(12'h123, "R13 foreign addr zero");

      // random mix
      for (int i = 0; i < 4000; i++) begin
         int unsigned op = $urandom_range(0, 9);
         int unsigned t  = $urandom_range(0, NT - 1);
         idle();
         cur_priv = 2'($urandom_range(0, 3));
         if (op == 0) begin
            csr_wr = 1'b1; csr_addr = 12'h7a0;
            csr_wdata = ($urandom_range(0, 7) == 0) ? 32'($urandom_range(NT, 16)) : 32'($urandom_range(0, NT - 1));
         end else if (op == 1) begin
            csr_wr = 1'b1; csr_addr = 12'h7a1;
            csr_wdata = ($urandom_range(0, 3) == 0) ? 32'd0 : $urandom();
         end else if (op == 2) begin
            csr_wr = 1'b1; csr_addr = 12'h7a2;
            csr_wdata = 32'($urandom_range(0, 15)) << 2;
         end else begin
            csr_addr = 12'(12'h7a0 + $urandom_range(0, 3));
         end
         fetch_valid = 1'($urandom_range(0, 1));
         ld_valid    = 1'($urandom_range(0, 1));
         st_valid    = 1'($urandom_range(0, 1));
         fetch_pc = ($urandom_range(0, 1) == 1) ? m_addr[t] : 32'($urandom_range(0, 15)) << 2;
         ld_addr  = ($urandom_range(0, 1) == 1) ? m_addr[t] : 32'($urandom_range(0, 15)) << 2;
         st_addr  = ($urandom_range(0, 1) == 1) ? m_addr[t] : $urandom();
         if (!csr_wr) rd(csr_addr, "R2 random read");
         step("R9 random request");
      end

      idle();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule